// File: doc/BRIEF.md
# Bitwise Three-Input LUT Unit

This block evaluates an arbitrary three-input Boolean function over a 64-bit word. For each bit position it takes one bit from the old destination value (T), one from operand A and one from operand B. These three bits form a 3-bit index into an 8-entry truth table. The table is either an 8-bit immediate that arrives already assembled, or the low byte of a fourth operand C. Any three-input function, including XOR-of-three, majority and a bitwise multiplexer, is selected by choosing the table.

Two further behaviours extend the plain bitwise form:

- **Whole-word mode.** Each operand is reduced to a single nonzero flag, and the result is a lone 0 or 1 in bit 0.
- **Packed byte-lane form.** The three low bytes of A act as the three selector lanes. The resulting byte is written into the low byte lanes enabled by a 4-bit mask. Every other byte keeps the old destination value.

Results are registered and carry a valid flag one cycle behind the request.

Top module: `lut3_unit`

## Requirements
- R1: With `packed_en`=0 and `mode` not 2'b01, result bit i equals table bit {T[i],A[i],B[i]}, where T is the most significant index bit and B the least.
- R2: `tbl_from_reg`=0 selects `imm_tbl` as the table. `tbl_from_reg`=1 selects `c_val[7:0]`, and `c_val[63:8]` has no effect.
- R3: With `packed_en`=0 and `mode`=2'b01, the result is 63 zero bits above bit 0. Bit 0 equals table bit {(T!=0),(A!=0),(B!=0)}.
- R4: `mode` codes 2'b00, 2'b10 and 2'b11 all give the bitwise result of R1.
- R5: With `packed_en`=1, lanes x=A[7:0], y=A[15:8] and z=A[23:16] form the lane result. Bit k of the lane result is table bit {x[k],y[k],z[k]}. Result byte j (j=0..3) takes the lane result when `lane_mask[j]`=1 and takes T byte j otherwise. Bytes 4..7 always equal T, and `mode` and B have no effect.
- R6: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `result` is loaded only on such edges and holds its value otherwise.
- R7: While `rst_n` is low, `out_valid` is 0 and `result` is zero.
- R8: Table 0xE2 in bitwise mode gives (T & A) | (B & ~A), a per-bit multiplexer steered by A. Table 0x96 gives T^A^B, and table 0xE8 gives the majority of the three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| packed_en | input | 1 | 1 selects the packed byte-lane form |
| tbl_from_reg | input | 1 | 1 takes the table from c_val[7:0] |
| mode | input | 2 | 2'b01 selects whole-word mode; other codes are bitwise |
| imm_tbl | input | 8 | Immediate truth table |
| t_old | input | 64 | Old destination value (most significant selector) |
| a_val | input | 64 | Operand A |
| b_val | input | 64 | Operand B |
| c_val | input | 64 | Operand C, low byte is the register table |
| lane_mask | input | 4 | Byte-lane write enables for the packed form |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
The register capture of a new operation and the presentation of the previous result fall in the same cycle when requests arrive back to back. This is provoked by issuing consecutive operations on successive cycles. Each one switches the table source, the mode and the packed form, so that a stale operand or table would show. Each result is compared against an independent model at the falling edge after its capture, while `out_valid` must stay high throughout.

// File: rtl/lut3_pkg.sv
package lut3_pkg;

   localparam int TBL_W = 8;
   localparam int IDX_W = 3;

   typedef enum logic [1:0] {
      LM_BITWISE = 2'b00,
      LM_WHOLE   = 2'b01,
      LM_SPARE2  = 2'b10,
      LM_SPARE3  = 2'b11
   } lut_mode_e;

   function automatic logic lut_pick(input logic [TBL_W-1:0] tbl,
                                     input logic hi, input logic mid,
                                     input logic lo);
      logic [IDX_W-1:0] idx;
      idx = {hi, mid, lo};
      return tbl[idx];
   endfunction

endpackage

// File: rtl/lut3_table_sel.sv
module lut3_table_sel
   import lut3_pkg::*;
(
   input  logic [TBL_W-1:0] imm_tbl,
   input  logic [TBL_W-1:0] reg_tbl,
   input  logic             from_reg,
   output logic [TBL_W-1:0] tbl
);
   assign tbl = from_reg ? reg_tbl : imm_tbl;
endmodule

// File: rtl/lut3_bitwise.sv
module lut3_bitwise
   import lut3_pkg::*;
#(
   parameter int WIDTH     = 64,
   parameter bit HAS_WHOLE = 1'b1
) (
   input  logic [TBL_W-1:0] tbl,
   input  logic [WIDTH-1:0] t_in,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             whole_en,
   output logic [WIDTH-1:0] res
);
   logic [WIDTH-1:0] per_bit;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign per_bit[i] = lut_pick(tbl, t_in[i], a_in[i], b_in[i]);
   end

   if (HAS_WHOLE) begin : g_whole
      logic flag_res;
      assign flag_res = lut_pick(tbl, |t_in, |a_in, |b_in);
      assign res = whole_en ? {{(WIDTH-1){1'b0}}, flag_res} : per_bit;
   end else begin : g_no_whole
      logic unused_whole;
      assign unused_whole = whole_en;
      assign res = per_bit;
   end
endmodule

// File: rtl/lut3_packed.sv
module lut3_packed
   import lut3_pkg::*;
#(
   parameter int WIDTH      = 64,
   parameter int LANE_W     = 8,
   parameter int MASK_LANES = 4
) (
   input  logic [TBL_W-1:0]      tbl,
   input  logic [WIDTH-1:0]      t_in,
   input  logic [3*LANE_W-1:0]   src_lanes,
   input  logic [MASK_LANES-1:0] lane_mask,
   output logic [WIDTH-1:0]      res
);
   localparam int NLANES = WIDTH / LANE_W;

   logic [LANE_W-1:0] lane_res;

   for (genvar k = 0; k < LANE_W; k++) begin : g_lbit
      assign lane_res[k] = lut_pick(tbl, src_lanes[k],
                                    src_lanes[LANE_W+k],
                                    src_lanes[2*LANE_W+k]);
   end

   for (genvar j = 0; j < NLANES; j++) begin : g_lane
      if (j < MASK_LANES) begin : g_masked
         assign res[j*LANE_W +: LANE_W] =
            lane_mask[j] ? lane_res : t_in[j*LANE_W +: LANE_W];
      end else begin : g_keep
         assign res[j*LANE_W +: LANE_W] = t_in[j*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/lut3_unit.sv
module lut3_unit
   import lut3_pkg::*;
#(
   parameter int WIDTH      = 64,
   parameter int LANE_W     = 8,
   parameter int MASK_LANES = 4,
   parameter bit HAS_WHOLE  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  packed_en,
   input  logic                  tbl_from_reg,
   input  logic [1:0]            mode,
   input  logic [7:0]            imm_tbl,
   input  logic [WIDTH-1:0]      t_old,
   input  logic [WIDTH-1:0]      a_val,
   input  logic [WIDTH-1:0]      b_val,
   input  logic [WIDTH-1:0]      c_val,
   input  logic [MASK_LANES-1:0] lane_mask,
   output logic                  out_valid,
   output logic [WIDTH-1:0]      result
);
   localparam int SRC_W = 3 * LANE_W;

   if (WIDTH % LANE_W != 0)
      $error("WIDTH must be a whole number of lanes");
   if (SRC_W > WIDTH)
      $error("three source lanes must fit in WIDTH");
   if (MASK_LANES * LANE_W > WIDTH)
      $error("masked lanes must fit in WIDTH");
   if (WIDTH <= TBL_W)
      $error("WIDTH must exceed the table width");

   logic [TBL_W-1:0] tbl;
   logic [WIDTH-1:0] bw_res;
   logic [WIDTH-1:0] pk_res;
   logic [WIDTH-1:0] next_res;
   logic             whole_en;
   logic             unused_c;

   assign unused_c = ^c_val[WIDTH-1:TBL_W];
   assign whole_en = (lut_mode_e'(mode) == LM_WHOLE);

   lut3_table_sel u_tsel (
      .imm_tbl  (imm_tbl),
      .reg_tbl  (c_val[TBL_W-1:0]),
      .from_reg (tbl_from_reg),
      .tbl      (tbl)
   );

   lut3_bitwise #(.WIDTH(WIDTH), .HAS_WHOLE(HAS_WHOLE)) u_bitwise (
      .tbl      (tbl),
      .t_in     (t_old),
      .a_in     (a_val),
      .b_in     (b_val),
      .whole_en (whole_en),
      .res      (bw_res)
   );

   lut3_packed #(.WIDTH(WIDTH), .LANE_W(LANE_W), .MASK_LANES(MASK_LANES)) u_packed (
      .tbl       (tbl),
      .t_in      (t_old),
      .src_lanes (a_val[SRC_W-1:0]),
      .lane_mask (lane_mask),
      .res       (pk_res)
   );

   assign next_res = packed_en ? pk_res : bw_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

   // R6
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R6
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   // R7
   always_ff @(posedge clk) begin
      reset_clear_chk: assert (rst_n || (!out_valid && result == '0));
   end
   // R5
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && packed_en) |=>
      result[WIDTH-1:MASK_LANES*LANE_W] == $past(t_old[WIDTH-1:MASK_LANES*LANE_W]));

   for (genvar j = 0; j < MASK_LANES; j++) begin : g_lane_chk
      // R5
      lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && packed_en && !lane_mask[j]) |=>
         result[j*LANE_W +: LANE_W] == $past(t_old[j*LANE_W +: LANE_W]));
   end

   if (HAS_WHOLE) begin : g_whole_chk
      // R3
      whole_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !packed_en && mode == 2'b01) |=> result[WIDTH-1:1] == '0);
   end

   // R1
   zero_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !packed_en && !tbl_from_reg && imm_tbl == 8'h00) |=> result == '0);
endmodule

// File: tb/lut3_unit_bench.sv
`timescale 1ns/1ps
module lut3_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        packed_en = 1'b0;
   logic        tbl_from_reg = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  imm_tbl = 8'h00;
   logic [63:0] t_old = '0, a_val = '0, b_val = '0, c_val = '0;
   logic [3:0]  lane_mask = 4'h0;
   logic        out_valid;
   logic [63:0] result;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   lut3_unit u_lut3_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .packed_en(packed_en),
      .tbl_from_reg(tbl_from_reg), .mode(mode), .imm_tbl(imm_tbl),
      .t_old(t_old), .a_val(a_val), .b_val(b_val), .c_val(c_val),
      .lane_mask(lane_mask), .out_valid(out_valid), .result(result)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [63:0] ref_bits(input logic [7:0] tb,
      input logic [63:0] t, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[i] = tb[{t[i], a[i], b[i]}];
      return r;
   endfunction

   function automatic logic [63:0] ref_whole(input logic [7:0] tb,
      input logic [63:0] t, input logic [63:0] a, input logic [63:0] b);
      logic [2:0] ix;
      ix = {t != 0, a != 0, b != 0};
      return {63'd0, tb[ix]};
   endfunction

   function automatic logic [63:0] ref_packed(input logic [7:0] tb,
      input logic [63:0] t, input logic [63:0] a, input logic [3:0] m);
      logic [7:0]  ln;
      logic [63:0] r;
      for (int k = 0; k < 8; k++) ln[k] = tb[{a[k], a[8+k], a[16+k]}];
      r = t;
      for (int j = 0; j < 4; j++) if (m[j]) r[j*8 +: 8] = ln;
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic pk, input logic fr, input logic [1:0] md,
      input logic [7:0] im, input logic [63:0] t, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] c, input logic [3:0] m);
      packed_en = pk; tbl_from_reg = fr; mode = md; imm_tbl = im;
      t_old = t; a_val = a; b_val = b; c_val = c; lane_mask = m;
      in_valid = 1'b1;
   endtask

   task automatic run_op(input logic pk, input logic fr, input logic [1:0] md,
      input logic [7:0] im, input logic [63:0] t, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] c, input logic [3:0] m);
      drive(pk, fr, md, im, t, a, b, c, m);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic test_reset;
      check("R7 out_valid in reset", {63'd0, out_valid}, 64'd0);
      check("R7 result in reset", result, 64'd0);
   endtask

   task automatic test_bitwise_tables;
      logic [7:0]  tabs [4];
      logic [63:0] ts [3];
      logic [63:0] as [3];
      logic [63:0] bs [3];
      tabs[0] = 8'h00; tabs[1] = 8'hFF; tabs[2] = 8'h96; tabs[3] = 8'hE8;
      ts[0] = 64'hF0F0_F0F0_F0F0_F0F0; as[0] = 64'hCCCC_CCCC_CCCC_CCCC; bs[0] = 64'hAAAA_AAAA_AAAA_AAAA;
      ts[1] = 64'h0123_4567_89AB_CDEF; as[1] = 64'hDEAD_BEEF_CAFE_F00D; bs[1] = 64'h8000_0000_0000_0001;
      ts[2] = 64'hFFFF_0000_FFFF_0000; as[2] = 64'h0000_0000_0000_0000; bs[2] = 64'h5A5A_A5A5_3C3C_C3C3;
      for (int ti = 0; ti < 4; ti++)
         for (int p = 0; p < 3; p++) begin
            run_op(1'b0, 1'b0, 2'b00, tabs[ti], ts[p], as[p], bs[p], 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
            check($sformatf("R1 table %h pattern %0d", tabs[ti], p), result,
                  ref_bits(tabs[ti], ts[p], as[p], bs[p]));
         end
      run_op(1'b0, 1'b0, 2'b00, 8'h96, ts[1], as[1], bs[1], 64'd0, 4'h0);
      check("R8 xor3", result, ts[1] ^ as[1] ^ bs[1]);
      run_op(1'b0, 1'b0, 2'b00, 8'hE8, ts[1], as[1], bs[1], 64'd0, 4'h0);
      check("R8 majority", result, (ts[1] & as[1]) | (ts[1] & bs[1]) | (as[1] & bs[1]));
   endtask

   task automatic test_reg_table;
      logic [63:0] t, a, b;
      t = 64'h1357_9BDF_0246_8ACE; a = 64'hFEDC_BA98_7654_3210; b = 64'h0F1E_2D3C_4B5A_6978;
      run_op(1'b0, 1'b1, 2'b00, 8'h00, t, a, b, 64'hA5A5_A5A5_A5A5_A596, 4'h0);
      check("R2 register table, upper C ignored", result, ref_bits(8'h96, t, a, b));
      run_op(1'b0, 1'b1, 2'b00, 8'hFF, t, a, b, 64'hFFFF_FFFF_FFFF_FF00, 4'h0);
      check("R2 register table zero, imm ignored", result, 64'd0);
      run_op(1'b0, 1'b0, 2'b00, 8'hE8, t, a, b, 64'h0000_0000_0000_00FF, 4'h0);
      check("R2 immediate table, C ignored", result, ref_bits(8'hE8, t, a, b));
   endtask

   task automatic test_whole;
      run_op(1'b0, 1'b0, 2'b01, 8'b0000_0100, 64'd0, 64'h8000_0000_0000_0000, 64'd0, 64'd0, 4'h0);
      check("R3 whole idx 010", result, 64'd1);
      run_op(1'b0, 1'b0, 2'b01, 8'b1111_1011, 64'd0, 64'h8000_0000_0000_0000, 64'd0, 64'd0, 4'h0);
      check("R3 whole idx 010 cleared", result, 64'd0);
      run_op(1'b0, 1'b0, 2'b01, 8'h96, 64'h10, 64'h1_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 4'h0);
      check("R3 whole xor all nonzero", result, ref_whole(8'h96, 64'h10, 64'h1_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF));
      run_op(1'b0, 1'b1, 2'b01, 8'h00, 64'd0, 64'd0, 64'd0, 64'hFF00_0000_0000_0001, 4'h0);
      check("R3 whole all zero register table", result, 64'd1);
   endtask

   task automatic test_spare_modes;
      logic [63:0] t, a, b;
      t = 64'hAAAA_5555_0000_FFFF; a = 64'h3333_CCCC_1111_EEEE; b = 64'h0F0F_F0F0_7777_8888;
      run_op(1'b0, 1'b0, 2'b10, 8'hE8, t, a, b, 64'd0, 4'h0);
      check("R4 mode 10 bitwise", result, ref_bits(8'hE8, t, a, b));
      run_op(1'b0, 1'b0, 2'b11, 8'h96, t, a, b, 64'd0, 4'h0);
      check("R4 mode 11 bitwise", result, ref_bits(8'h96, t, a, b));
   endtask

   task automatic test_packed;
      logic [63:0] t, a;
      logic [3:0]  ms [4];
      t = 64'h8877_6655_4433_2211; a = 64'hDEAD_BEEF_F0CC_AA12;
      ms[0] = 4'b0000; ms[1] = 4'b1111; ms[2] = 4'b0101; ms[3] = 4'b1000;
      for (int q = 0; q < 4; q++) begin
         run_op(1'b1, 1'b0, 2'b01, 8'hE8, t, a, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, ms[q]);
         check($sformatf("R5 packed mask %b", ms[q]), result, ref_packed(8'hE8, t, a, ms[q]));
      end
      run_op(1'b1, 1'b1, 2'b00, 8'h00, t, a, 64'd0, 64'h1234_5678_9ABC_DE96, 4'b0110);
      check("R5 packed register table", result, ref_packed(8'h96, t, a, 4'b0110));
   endtask

   task automatic test_mux;
      logic [63:0] t, a, b;
      t = 64'hFFFF_FFFF_0000_0000; a = 64'hFF00_FF00_FF00_FF00; b = 64'h0F0F_0F0F_0F0F_0F0F;
      run_op(1'b0, 1'b0, 2'b00, 8'hE2, t, a, b, 64'd0, 4'h0);
      check("R8 mux table E2", result, (t & a) | (b & ~a));
   endtask

   task automatic test_valid_hold;
      logic [63:0] held;
      run_op(1'b0, 1'b0, 2'b00, 8'hFF, 64'd0, 64'd0, 64'd0, 64'd0, 4'h0);
      check("R6 out_valid after request", {63'd0, out_valid}, 64'd1);
      held = result;
      packed_en = 1'b0; imm_tbl = 8'h00; t_old = 64'h1; a_val = 64'h2; b_val = 64'h3;
      in_valid = 1'b0;
      @(negedge clk);
      check("R6 out_valid low without request", {63'd0, out_valid}, 64'd0);
      check("R6 result held without request", result, held);
   endtask

   task automatic test_back_to_back;
      logic [63:0] t, a, b;
      t = 64'h0F0F_3333_5555_AAAA; a = 64'h00FF_00FF_C3C3_1248; b = 64'h7E7E_8181_6969_9999;
      drive(1'b0, 1'b0, 2'b00, 8'h96, t, a, b, 64'd0, 4'h0);
      @(negedge clk);
      check("R6 b2b op1", result, ref_bits(8'h96, t, a, b));
      drive(1'b1, 1'b1, 2'b01, 8'h00, t, a, b, 64'h55AA_55AA_55AA_55E8, 4'b1010);
      @(negedge clk);
      check("R6 b2b op2 valid", {63'd0, out_valid}, 64'd1);
      check("R5 b2b op2 packed", result, ref_packed(8'hE8, t, a, 4'b1010));
      drive(1'b0, 1'b0, 2'b01, 8'h80, t, a, b, 64'd0, 4'h0);
      @(negedge clk);
      in_valid = 1'b0;
      check("R3 b2b op3 whole", result, 64'd1);
      @(negedge clk);
      check("R6 b2b valid drops", {63'd0, out_valid}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset;
      rst_n = 1'b1;
      @(negedge clk);
      test_bitwise_tables;
      test_reg_table;
      test_whole;
      test_spare_modes;
      test_packed;
      test_mux;
      test_valid_hold;
      test_back_to_back;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule